// File: doc/BRIEF.md
# Dual-Bus Register Bank

A bank of general-purpose registers that sits between two internal data buses of a processor data path, named here the A side and the B side. In every cycle each side can independently read one register onto its bus and write one register from its bus. Read selects, drive enables, write selects and write enables all come from an external controller. The bank carries no tristate nets. Each bus appears as a read-data output and a write-data input, and an explicit enable gates each of them.

A bus whose drive enable is low outputs zero, so the surrounding logic can merge several sources with a plain OR. Reads come from the register state combinationally. Writes take effect at the rising clock edge, so a read in the cycle of a write returns the old value. The controller is expected not to aim both writes at one register in the same cycle. If it does, the A-side write wins, and a simulation-only check reports the collision.

Top module: `dbrb_top`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), all NREGS registers (default 8, each WIDTH = 16 bits) read as zero.
- R2: With a_drv_en high, a_rdata equals the current value of the register selected by a_rsel. With b_drv_en high, b_rdata equals the current value of the register selected by b_rsel. Both sides can read at the same time.
- R3: When a_rsel equals b_rsel and both drive enables are high, both outputs carry the same value.
- R4: A drive enable that is low forces its read-data output to all zeros.
- R5: With a_ld_en high, a_wdata is stored into register a_wsel at the rising edge. b_ld_en, b_wsel and b_wdata do the same for the B side. Two different registers may be written in one cycle.
- R6: A write becomes visible only after the edge: a read of the target register in the same cycle returns the previous value.
- R7: Registers that no enabled write selects keep their value. In the same cycle, one side can write while the other side reads.
- R8: If both load enables are high and both write selects name the same register, that register takes a_wdata. The checker reports this case as a controller error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| a_rsel | input | 3 | Register driven onto the A bus |
| a_drv_en | input | 1 | Enables the A-bus read output |
| a_rdata | output | 16 | A-bus read data, zero when not enabled |
| b_rsel | input | 3 | Register driven onto the B bus |
| b_drv_en | input | 1 | Enables the B-bus read output |
| b_rdata | output | 16 | B-bus read data, zero when not enabled |
| a_wsel | input | 3 | Register loaded from the A bus |
| a_ld_en | input | 1 | Enables the load from the A bus |
| a_wdata | input | 16 | Data on the A bus for loading |
| b_wsel | input | 3 | Register loaded from the B bus |
| b_ld_en | input | 1 | Enables the load from the B bus |
| b_wdata | input | 16 | Data on the B bus for loading |

## Verification
The bench goes after the collision of both writes on one register. A design that gave priority to the B side, or merged the two data words, would leave the wrong value in that register. It reads a register in the same cycle it is written: a bank that bypassed write data to the read port would show the new value one cycle early. It drives both buses from one register, and it turns off each drive enable in turn to catch an output that leaks the register value instead of zero. Random traffic, run against a bench-side model, exposes writes that land in neighbouring registers or disturb registers nobody selected.

// File: rtl/dbrb_pkg.sv
package dbrb_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_A    = 2'd1,
    WR_B    = 2'd2
  } wr_src_e;

  // Resolve which side writes a given register: the A side wins a collision.
  function automatic wr_src_e pick_src(input logic hit_a, input logic hit_b);
    if (hit_a)      return WR_A;
    else if (hit_b) return WR_B;
    else            return WR_NONE;
  endfunction

  // A gated bus value: zero when not driven.
  function automatic logic [63:0] gate_bus(input logic en, input logic [63:0] v);
    return en ? v : '0;
  endfunction
endpackage

// File: rtl/dbrb_wdec.sv
module dbrb_wdec #(
  parameter int NREGS = 8,
  parameter int SELW  = $clog2(NREGS)
) (
  input  logic [SELW-1:0]  a_wsel,
  input  logic             a_ld_en,
  input  logic [SELW-1:0]  b_wsel,
  input  logic             b_ld_en,
  output logic [NREGS-1:0] hit_a,
  output logic [NREGS-1:0] hit_b
);
  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    assign hit_a[i] = a_ld_en && (a_wsel == SELW'(i));
    assign hit_b[i] = b_ld_en && (b_wsel == SELW'(i));
  end
endmodule

// File: rtl/dbrb_cell.sv
module dbrb_cell
  import dbrb_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] q
);
  wr_src_e src;
  assign src = pick_src(hit_a, hit_b);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      case (src)
        WR_A:    q <= a_wdata;
        WR_B:    q <= b_wdata;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dbrb_rport.sv
module dbrb_rport
  import dbrb_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int WIDTH = 16,
  parameter int SELW  = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][WIDTH-1:0] regs,
  input  logic [SELW-1:0]             rsel,
  input  logic                        drv_en,
  output logic [WIDTH-1:0]            rdata
);
  logic [WIDTH-1:0] picked;
  logic [63:0]      gated;
  assign picked = regs[rsel];
  assign gated  = gate_bus(drv_en, 64'(picked));
  assign rdata  = gated[WIDTH-1:0];
endmodule

// File: rtl/dbrb_top.sv
module dbrb_top #(
  parameter int NREGS = 8,
  parameter int WIDTH = 16,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SELW-1:0]  a_rsel,
  input  logic             a_drv_en,
  output logic [WIDTH-1:0] a_rdata,
  input  logic [SELW-1:0]  b_rsel,
  input  logic             b_drv_en,
  output logic [WIDTH-1:0] b_rdata,
  input  logic [SELW-1:0]  a_wsel,
  input  logic             a_ld_en,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic [SELW-1:0]  b_wsel,
  input  logic             b_ld_en,
  input  logic [WIDTH-1:0] b_wdata
);
  logic [NREGS-1:0]            hit_a, hit_b;
  logic [NREGS-1:0][WIDTH-1:0] regs;
  logic                        wr_clash;

  assign wr_clash = |(hit_a & hit_b);

  dbrb_wdec #(.NREGS(NREGS)) u_wdec (
    .a_wsel(a_wsel), .a_ld_en(a_ld_en),
    .b_wsel(b_wsel), .b_ld_en(b_ld_en),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    dbrb_cell #(.WIDTH(WIDTH)) u_cell (
      .clk(clk), .rst(rst),
      .hit_a(hit_a[i]), .hit_b(hit_b[i]),
      .a_wdata(a_wdata), .b_wdata(b_wdata),
      .q(regs[i])
    );
  end

  dbrb_rport #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rport_a (
    .regs(regs), .rsel(a_rsel), .drv_en(a_drv_en), .rdata(a_rdata)
  );
  dbrb_rport #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rport_b (
    .regs(regs), .rsel(b_rsel), .drv_en(b_drv_en), .rdata(b_rdata)
  );
endmodule

// File: rtl/dbrb_chk.sv
module dbrb_chk #(
  parameter int NREGS = 8,
  parameter int WIDTH = 16,
  parameter int SELW  = $clog2(NREGS)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [SELW-1:0]             a_rsel,
  input logic                        a_drv_en,
  input logic [WIDTH-1:0]            a_rdata,
  input logic [SELW-1:0]             b_rsel,
  input logic                        b_drv_en,
  input logic [WIDTH-1:0]            b_rdata,
  input logic [SELW-1:0]             a_wsel,
  input logic                        a_ld_en,
  input logic [WIDTH-1:0]            a_wdata,
  input logic [SELW-1:0]             b_wsel,
  input logic                        b_ld_en,
  input logic [WIDTH-1:0]            b_wdata,
  input logic [NREGS-1:0][WIDTH-1:0] regs,
  input logic                        wr_clash
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  // R4
  idle_a_zero_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !a_drv_en |-> a_rdata == '0);
  // R4
  idle_b_zero_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !b_drv_en |-> b_rdata == '0);
  // R3
  same_sel_chk: assert property (@(posedge clk) disable iff (rst || !started)
    (a_drv_en && b_drv_en && a_rsel == b_rsel) |-> a_rdata == b_rdata);
  // R5
  a_load_chk: assert property (@(posedge clk) disable iff (rst || !started)
    a_ld_en |=> regs[$past(a_wsel)] == $past(a_wdata));
  // R5
  b_load_chk: assert property (@(posedge clk) disable iff (rst || !started)
    (b_ld_en && !(a_ld_en && a_wsel == b_wsel)) |=> regs[$past(b_wsel)] == $past(b_wdata));
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> regs == '0);
  // R8
  no_wr_clash_chk: assert property (@(posedge clk) disable iff (rst || !started)
    !wr_clash)
    else $warning("controller aimed both writes at register %0d", a_wsel);
endmodule

bind dbrb_top dbrb_chk #(.NREGS(NREGS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst),
  .a_rsel(a_rsel), .a_drv_en(a_drv_en), .a_rdata(a_rdata),
  .b_rsel(b_rsel), .b_drv_en(b_drv_en), .b_rdata(b_rdata),
  .a_wsel(a_wsel), .a_ld_en(a_ld_en), .a_wdata(a_wdata),
  .b_wsel(b_wsel), .b_ld_en(b_ld_en), .b_wdata(b_wdata),
  .regs(regs), .wr_clash(wr_clash)
);

// File: tb/dbrb_top_bench.sv
`timescale 1ns/1ps
module dbrb_top_bench;
  localparam int N = 8;
  localparam int W = 16;

  logic clk = 0, rst = 1;
  logic [2:0] a_rsel = 0, b_rsel = 0, a_wsel = 0, b_wsel = 0;
  logic a_drv_en = 0, b_drv_en = 0, a_ld_en = 0, b_ld_en = 0;
  logic [W-1:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
  logic [W-1:0] model [N];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbrb_top u_dbrb_top (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_bus(bit en, logic [2:0] sel);
    return en ? model[sel] : '0;
  endfunction

  // Apply write controls, step one edge, update model (A wins on clash).
  task automatic do_write(bit ae, logic [2:0] as, logic [W-1:0] ad,
                          bit be, logic [2:0] bs, logic [W-1:0] bd);
    a_ld_en = ae; a_wsel = as; a_wdata = ad;
    b_ld_en = be; b_wsel = bs; b_wdata = bd;
    @(posedge clk); #1;
    if (be) model[bs] = bd;
    if (ae) model[as] = ad;
    a_ld_en = 0; b_ld_en = 0;
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) begin
      a_drv_en = 1; a_rsel = 3'(i); b_drv_en = 1; b_rsel = 3'(N-1-i);
      #1;
      chk(req, a_rdata, model[i]);
      chk(req, b_rdata, model[N-1-i]);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    // Dirty registers before reset.
    rst = 0;
    @(posedge clk); #1;
    a_ld_en = 1; a_wsel = 3; a_wdata = 16'hDEAD;
    @(posedge clk); #1;
    a_ld_en = 0; rst = 1;
    @(posedge clk); #1;
    rst = 0;
    read_all("R1");

    // R5: two different registers in one cycle
    do_write(1, 2, 16'h1234, 1, 5, 16'hABCD);
    read_all("R5");

    // R3: same register on both buses
    a_drv_en = 1; b_drv_en = 1; a_rsel = 5; b_rsel = 5; #1;
    chk("R3", a_rdata, 16'hABCD);
    chk("R3", b_rdata, 16'hABCD);

    // R4: drive enables off
    a_drv_en = 0; #1;
    chk("R4", a_rdata, 16'h0000);
    chk("R4", b_rdata, 16'hABCD);
    a_drv_en = 1; b_drv_en = 0; #1;
    chk("R4", b_rdata, 16'h0000);
    chk("R4", a_rdata, 16'hABCD);

    // R6/R7: write reg 2 from B while A reads reg 2 in the same cycle
    a_drv_en = 1; a_rsel = 2; b_drv_en = 0;
    b_ld_en = 1; b_wsel = 2; b_wdata = 16'h5A5A; #1;
    chk("R6", a_rdata, 16'h1234);
    @(posedge clk); #1;
    b_ld_en = 0; model[2] = 16'h5A5A;
    chk("R7", a_rdata, 16'h5A5A);
    read_all("R7");

    // R8: collision, A wins
    do_write(1, 6, 16'hAAAA, 1, 6, 16'hBBBB);
    a_drv_en = 1; a_rsel = 6; #1;
    chk("R8", a_rdata, 16'hAAAA);
    read_all("R8");

    // Random traffic without collisions
    void'($urandom(32'd77));
    for (int k = 0; k < 400; k++) begin
      logic [2:0] as, bs;
      bit ae, be;
      as = 3'($urandom_range(0, N-1));
      bs = 3'($urandom_range(0, N-1));
      ae = bit'($urandom_range(0, 1));
      be = bit'($urandom_range(0, 1));
      if (ae && be && as == bs) be = 0;
      a_drv_en = bit'($urandom_range(0, 1)); a_rsel = 3'($urandom_range(0, N-1));
      b_drv_en = bit'($urandom_range(0, 1)); b_rsel = 3'($urandom_range(0, N-1));
      #1;
      chk("R2", a_rdata, expect_bus(a_drv_en, a_rsel));
      chk("R2", b_rdata, expect_bus(b_drv_en, b_rsel));
      do_write(ae, as, W'($urandom), be, bs, W'($urandom));
    end
    read_all("R7");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule